// File: doc/BRIEF.md
# Programmable Watchdog Timer with Multiplier and Resolution Encoding

This block is a watchdog timer programmed through one 8-bit register. The register holds three fields: a 2-bit resolution code, a 5-bit multiplier and a steering bit. The timeout is the multiplier times four raised to the resolution code, counted in periods of an external 16 Hz tick. Writing the register arms a new countdown. Reading the flags location also restarts the count, using the value the register already holds.

When the count runs out, the block sets a timeout flag. The steering bit then picks one of two actions. With the bit set, the block sends a one-cycle reset request, clears the whole watchdog register and clears one bit of a neighbouring control register. With the bit clear, the block sends one interrupt pulse and leaves the register unchanged. Software reaches the block through a small register port with four byte locations.

Top module: `wdog_timer`

## Requirements
- R1: After reset the flags, watchdog and control locations all read 0x00, and the reset-request and interrupt outputs are low.
- R2: The timeout in ticks is the multiplier (bits 6:2) times 4 to the power of the resolution code (bits 1:0). The expiry output rises in the clock cycle after the tick that completes the count, and never earlier.
- R3: A multiplier of zero disables the watchdog, so it never expires however many ticks arrive.
- R4: A write to the watchdog location (address 1) restarts the countdown from the new value and clears the timeout flag.
- R5: A read of the flags location (address 0) returns the timeout flag in bit 7, with the other bits zero. The same read clears the flag and restarts the countdown from the current watchdog value.
- R6: On expiry the timeout flag is set.
- R7: With the steering bit (bit 7) set at expiry, rst_req pulses high for exactly one cycle and irq stays low. The watchdog register becomes 0x00, and bit 6 of the control register (address 2) is cleared.
- R8: With the steering bit clear at expiry, irq pulses high for exactly one cycle, rst_req stays low and the watchdog register keeps its value.
- R9: After an expiry the block fires no further event until it is restarted by R4 or R5.
- R10: The flags location is read-only: a write to address 0 changes neither the flag nor the count.
- R11: A restart in the same cycle as the tick that would complete the count cancels that expiry.
- R12: Address 2 is a plain read/write control byte, and address 3 reads 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_16hz | input | 1 | One-cycle pulse at each 1/16 s period |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect at address 0) |
| addr | input | 2 | Location: 0 flags, 1 watchdog, 2 control, 3 unused |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions check four behaviours on every cycle:
- both events are single-cycle pulses and never occur together;
- an expiry always sets the flag and always coincides with a tick;
- a steered expiry clears the watchdog register and control bit 6;
- a restart suppresses expiry and clears the flag, and a zero multiplier never expires.

Some behaviours can only be shown by the bench's scenarios, because they depend on what happened over many cycles:
- the exact tick count of each timeout encoding;
- the one-shot behaviour after an expiry;
- the restart caused by reading the flags location;
- the value the flags location returns before that read clears it;
- the no-effect write to the flags location.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W    = 8;
  localparam int RES_W     = 2;
  localparam int MULT_W    = 5;
  localparam int MULT_LSB  = RES_W;
  localparam int STEER_BIT = DATA_W - 1;
  localparam int CTRL_BIT  = 6;
  localparam int CNT_W     = MULT_W + 2 * ((1 << RES_W) - 1);

  typedef enum logic [1:0] {
    SEL_FLAGS = 2'd0,
    SEL_WDOG  = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } sel_e;

  // multiplier scaled by 4**resolution, in tick periods
  function automatic logic [CNT_W-1:0] timeout_ticks(input logic [DATA_W-1:0] r);
    logic [CNT_W-1:0] m;
    m = CNT_W'(r[MULT_LSB +: MULT_W]);
    return m << (2 * r[RES_W-1:0]);
  endfunction
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (load)                       cnt_q <= load_val;
    else if (tick && cnt_q != '0)        cnt_q <= cnt_q - CNT_W'(1);
  end

  // the tick that takes the count from one to zero is the expiry
  assign expire = tick && !load && (cnt_q == CNT_W'(1));
  assign cnt    = cnt_q;
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              load,
  input  logic              expire,
  output logic [DATA_W-1:0] wdreg,
  output logic [DATA_W-1:0] ctrl,
  output logic              flag,
  output logic [DATA_W-1:0] rdata
);
  logic steer_hit;
  assign steer_hit = expire && wdreg[STEER_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              wdreg <= '0;
    else if (wr_en && addr == SEL_WDOG)      wdreg <= wdata;
    else if (steer_hit)                      wdreg <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= '0;
    else begin
      if (wr_en && addr == SEL_CTRL) ctrl <= wdata;
      if (steer_hit)                 ctrl[CTRL_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (load)   flag <= 1'b0;
    else if (expire) flag <= 1'b1;
  end

  always_comb begin
    unique case (addr)
      SEL_FLAGS: rdata = {flag, {(DATA_W-1){1'b0}}};
      SEL_WDOG:  rdata = wdreg;
      SEL_CTRL:  rdata = ctrl;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_events.sv
module wdog_events (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic steer,
  output logic rst_req,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req <= 1'b0;
      irq     <= 1'b0;
    end else begin
      rst_req <= expire &&  steer;
      irq     <= expire && !steer;
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_16hz,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rst_req,
  output logic              irq
);
  logic              wr_wdog_w, rd_flags_w, load_w, expire_w, flag_w;
  logic [DATA_W-1:0] wdreg_w, ctrl_w, load_src_w;
  logic [CNT_W-1:0]  load_val_w, cnt_w;

  assign wr_wdog_w  = wr_en && (addr == SEL_WDOG);
  assign rd_flags_w = rd_en && (addr == SEL_FLAGS);
  assign load_w     = wr_wdog_w || rd_flags_w;
  assign load_src_w = wr_wdog_w ? wdata : wdreg_w;
  assign load_val_w = timeout_ticks(load_src_w);

  wdog_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .load(load_w), .expire(expire_w), .wdreg(wdreg_w), .ctrl(ctrl_w),
    .flag(flag_w), .rdata(rdata)
  );

  wdog_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_16hz), .load(load_w),
    .load_val(load_val_w), .expire(expire_w), .cnt(cnt_w)
  );

  wdog_events u_evt (
    .clk(clk), .rst_n(rst_n), .expire(expire_w),
    .steer(wdreg_w[STEER_BIT]), .rst_req(rst_req), .irq(irq)
  );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk
  import wdog_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              rst_req,
  input logic              irq,
  input logic              expire,
  input logic              load,
  input logic              flag,
  input logic [DATA_W-1:0] wdreg,
  input logic [DATA_W-1:0] ctrl
);
  a_r7_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && irq));
  a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);
  a_r2_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> tick);
  a_r7_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && wdreg[STEER_BIT]) |=> (wdreg == '0) && !ctrl[CTRL_BIT] && rst_req);
  a_r8_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !wdreg[STEER_BIT]) |=> $stable(wdreg) && irq);
  a_r3_zero_mult: assert property (@(posedge clk) disable iff (!rst_n)
    (wdreg[MULT_LSB +: MULT_W] == '0) |-> !expire);
  a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !expire);
  a_r4_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !flag);
endmodule

bind wdog_timer wdog_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_16hz), .rst_req(rst_req), .irq(irq),
  .expire(expire_w), .load(load_w), .flag(flag_w), .wdreg(wdreg_w), .ctrl(ctrl_w)
);

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_16hz = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rst_req, irq;
  int         checks = 0;
  int         errors = 0;

  always #4 clk = ~clk;

  wdog_timer u_wdog_timer (
    .clk(clk), .rst_n(rst_n), .tick_16hz(tick_16hz), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rst_req(rst_req), .irq(irq)
  );

  // register value, tick count expected from the encoding
  localparam int NV = 6;
  localparam logic [18:0] VEC [NV] = '{
    {8'h04, 11'd1}, {8'h0D, 11'd12}, {8'h16, 11'd80},
    {8'h0B, 11'd128}, {8'h7C, 11'd31}, {8'h7F, 11'd1984}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  // returns whether any event output was seen after each tick
  task automatic ticks(input int n, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_16hz = 1'b1;
      @(negedge clk); tick_16hz = 1'b0;
      if (irq || rst_req) seen = 1'b1;
    end
  endtask

  initial begin
    logic [7:0] rv;
    bit seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rst_req", rst_req, 0);
    chk("R1 irq", irq, 0);
    bus_read(2'd0, rv); chk("R1 flags", rv, 8'h00);
    bus_read(2'd1, rv); chk("R1 wdog", rv, 8'h00);
    bus_read(2'd2, rv); chk("R1 ctrl", rv, 8'h00);
    rst_n = 1'b1;

    // R2 / R6 / R8 / R9 table walk
    for (int v = 0; v < NV; v++) begin
      logic [7:0] r;
      int exp_t;
      r = VEC[v][18:11];
      exp_t = int'(r[6:2]);
      for (int k = 0; k < int'(r[1:0]); k++) exp_t = exp_t * 4;
      chk("R2 table", exp_t, int'(VEC[v][10:0]));
      bus_write(2'd1, r);
      ticks(exp_t - 1, seen);
      chk("R2 no early event", seen, 0);
      ticks(1, seen);
      chk("R8 irq on expiry", irq, 1);
      chk("R8 no rst_req", rst_req, 0);
      @(negedge clk);
      chk("R8 irq single", irq, 0);
      bus_read(2'd1, rv); chk("R8 wdog kept", rv, r);
      ticks(3, seen);
      chk("R9 one-shot", seen, 0);
      bus_read(2'd0, rv); chk("R6 flag set", rv, 8'h80);
      bus_read(2'd0, rv); chk("R5 flag cleared by read", rv, 8'h00);
    end

    // R3 multiplier zero
    bus_write(2'd1, 8'h03);
    ticks(20, seen);
    chk("R3 disabled", seen, 0);
    bus_read(2'd0, rv); chk("R3 no flag", rv, 8'h00);

    // R4 rewrite restarts
    bus_write(2'd1, 8'h0C);
    ticks(2, seen);
    bus_write(2'd1, 8'h0C);
    ticks(2, seen);
    chk("R4 restart delays expiry", seen, 0);
    ticks(1, seen);
    chk("R4 expiry after restart", irq, 1);

    // R10 write to flags ignored, R5 read reloads
    bus_write(2'd0, 8'h00);
    bus_read(2'd0, rv); chk("R10 flag unchanged", rv, 8'h80);
    ticks(2, seen);
    bus_read(2'd0, rv);
    ticks(2, seen);
    chk("R5 read restarts", seen, 0);
    ticks(1, seen);
    chk("R5 expiry after read restart", irq, 1);
    bus_write(2'd1, 8'h0C);
    ticks(2, seen);
    bus_write(2'd0, 8'h00);
    ticks(1, seen);
    chk("R10 write does not restart", irq, 1);

    // R11 restart in the completing tick cycle
    bus_write(2'd1, 8'h04);
    @(negedge clk); tick_16hz = 1'b1; wr_en = 1'b1; addr = 2'd1; wdata = 8'h04;
    @(negedge clk); tick_16hz = 1'b0; wr_en = 1'b0;
    chk("R11 expiry cancelled", irq, 0);
    bus_read(2'd1, rv);
    ticks(1, seen);
    chk("R11 expiry on next tick", irq, 1);

    // R12 map
    bus_write(2'd3, 8'h5A);
    bus_read(2'd3, rv); chk("R12 unused reads zero", rv, 8'h00);
    bus_write(2'd2, 8'hFF);
    bus_read(2'd2, rv); chk("R12 ctrl readback", rv, 8'hFF);

    // R7 steered reset
    bus_write(2'd1, 8'h88);
    ticks(1, seen);
    chk("R7 no early event", seen, 0);
    ticks(1, seen);
    chk("R7 rst_req", rst_req, 1);
    chk("R7 no irq", irq, 0);
    @(negedge clk);
    chk("R7 rst_req single", rst_req, 0);
    bus_read(2'd1, rv); chk("R7 wdog cleared", rv, 8'h00);
    bus_read(2'd2, rv); chk("R7 ctrl bit6 cleared", rv, 8'hBF);
    bus_read(2'd0, rv); chk("R7 flag set", rv, 8'h80);
    ticks(5, seen);
    chk("R7 disarmed", seen, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL run limit actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule